// File: doc/BRIEF.md
# Six-Channel PWM with Channel Pairing

This block produces six left-aligned pulse-width-modulated lines from 8-bit period and duty registers. Each channel has an enable bit. All channels share one prescaler that divides the system clock by 2^PSC_W, and each prescaler wrap ("tick") steps the channel counters. When an enable bit is set, the output path opens at once. The counter only starts, and the waveform only shows, at the next prescaler tick.

Adjacent channels can be joined in pairs (0/1, 2/3, 4/5) to make one 16-bit channel. For a joined pair, the even channel's registers hold the high byte and the odd channel's registers hold the low byte. The odd enable bit alone starts and stops the pair. The waveform appears on the odd line, and the even line is held low whatever its enable bit says. When all enable bits are clear, the prescaler is held at zero to save power. Restarting from that state therefore always has the same latency.

Top module: `pwm_pair6`

## Requirements
- R1: Register 0 (enable, bit i = channel i) resets to 0 and reads back what was written, with bits 7 and 6 always reading 0. Writing only those bits starts no output.
- R2: After an enable bit is written with the prescaler stopped, the line stays low for exactly 2^PSC_W clock cycles after the write edge. It then shows its waveform, starting at the beginning of a period.
- R3: A running 8-bit channel with period P > 0 and duty D < P repeats every 2^PSC_W·P clocks and is high for 2^PSC_W·D clocks of each period.
- R4: Clearing an enable bit drives that line low in the cycle after the write, and the line stays low.
- R5: Register 1 bit p joins pair p (channels 2p and 2p+1). The joined pair uses period {per[2p],per[2p+1]} and duty {duty[2p],duty[2p+1]}, with its waveform on line 2p+1 and enabled by bit 2p+1.
- R6: While pair p is joined, enable bit 2p has no effect and line 2p stays low.
- R7: When all enable bits are 0, the prescaler stops and returns to zero, so a later enable again sees the R2 latency.
- R8: Duty 0 gives a line that is constantly low, and duty ≥ period gives a line that is constantly high while enabled.
- R9: Period registers sit at addresses 8+i and duty registers at 16+i (i = 0..5), and both read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 5 | Register address (read and write) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| pwm_out | output | 6 | PWM lines, bit i = channel i |

## Verification
The assertions assume that writes arrive as single-cycle strobes on a synchronous address and that reset is applied before the first write. They also assume that the pairing register is changed only while the affected channels are disabled. Under those assumptions, a started counter always follows a prescaler tick, and the gating of even lines and of the prescaler holds in every cycle. The stimulus follows these rules: it changes inputs only on falling edges, writes one register per strobe, and clears all enables before it reconfigures pairing.

// File: rtl/pwm_pair6.sv
module pwm_pair6 #(
  parameter int PSC_W = 2,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [5:0]    pwm_out
);
  localparam int NCH = 6;
  localparam int NPAIR = NCH / 2;

  logic [5:0]       en_r;
  logic [NPAIR-1:0] con_r;
  logic [7:0]       per_r  [NCH];
  logic [7:0]       duty_r [NCH];
  logic [PSC_W-1:0] psc;
  logic [5:0]       act;
  logic [5:0]       en_eff;
  logic             run, tick;

  wire sel_per  = (addr[4:3] == 2'b01) && (addr[2:0] < 3'd6);
  wire sel_duty = (addr[4:3] == 2'b10) && (addr[2:0] < 3'd6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r  <= '0;
      con_r <= '0;
      for (int i = 0; i < NCH; i++) begin
        per_r[i]  <= '0;
        duty_r[i] <= '0;
      end
    end else if (wr_en) begin
      if (addr == 5'd0) en_r <= wdata[5:0];
      if (addr == 5'd1) con_r <= wdata[NPAIR-1:0];
      if (sel_per)  per_r[addr[2:0]]  <= wdata;
      if (sel_duty) duty_r[addr[2:0]] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == 5'd0) rdata = {2'b00, en_r};
    else if (addr == 5'd1) rdata = {{(8-NPAIR){1'b0}}, con_r};
    else if (sel_per) rdata = per_r[addr[2:0]];
    else if (sel_duty) rdata = duty_r[addr[2:0]];
  end

  assign run  = |en_r;
  assign tick = run & (&psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc <= '0;
    else if (!run) psc <= '0;
    else psc <= psc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act <= '0;
    else act <= en_eff & (act | {6{tick}});
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [7:0]  chi, clo;
    logic [15:0] c16, p16, d16;
    logic        wrap16, wrap_hi, wrap_lo;
    logic        hi_line, lo_line;

    assign en_eff[2*p]   = en_r[2*p] & ~con_r[p];
    assign en_eff[2*p+1] = en_r[2*p+1];

    assign c16 = {chi, clo};
    assign p16 = {per_r[2*p], per_r[2*p+1]};
    assign d16 = {duty_r[2*p], duty_r[2*p+1]};
    assign wrap16  = ({1'b0, c16} + 17'd1) >= {1'b0, p16};
    assign wrap_hi = ({1'b0, chi} + 9'd1) >= {1'b0, per_r[2*p]};
    assign wrap_lo = ({1'b0, clo} + 9'd1) >= {1'b0, per_r[2*p+1]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chi <= '0;
        clo <= '0;
      end else if (con_r[p]) begin
        if (!act[2*p+1]) {chi, clo} <= '0;
        else if (tick) {chi, clo} <= wrap16 ? 16'd0 : c16 + 16'd1;
      end else begin
        if (!act[2*p]) chi <= '0;
        else if (tick) chi <= wrap_hi ? 8'd0 : chi + 8'd1;
        if (!act[2*p+1]) clo <= '0;
        else if (tick) clo <= wrap_lo ? 8'd0 : clo + 8'd1;
      end
    end

    assign hi_line = en_eff[2*p] & act[2*p] & (chi < duty_r[2*p]);
    assign lo_line = en_eff[2*p+1] & act[2*p+1] &
                     (con_r[p] ? (c16 < d16) : (clo < duty_r[2*p+1]));

    assign pwm_out[2*p]   = hi_line;
    assign pwm_out[2*p+1] = lo_line;
  end
endmodule

// File: rtl/pwm_pair6_chk.sv
module pwm_pair6_chk #(
  parameter int PSC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       en_r,
  input logic [2:0]       con_r,
  input logic [PSC_W-1:0] psc,
  input logic             tick,
  input logic [5:0]       act,
  input logic [5:0]       pwm_out
);
  for (genvar i = 0; i < 6; i++) begin : g_ch
    assert_sync_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act[i]) |-> $past(tick));
    assert_disabled_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_r[i] |-> !pwm_out[i]);
  end

  for (genvar p = 0; p < 3; p++) begin : g_pr
    assert_even_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      con_r[p] |-> !pwm_out[2*p]);
  end

  assert_psc_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r == 6'd0) |=> (psc == '0));
endmodule

bind pwm_pair6 pwm_pair6_chk #(.PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_r(en_r), .con_r(con_r),
  .psc(psc), .tick(tick), .act(act), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_pair6.sv
module tb_pwm_pair6;
  localparam int PSC_W = 2;
  localparam int DIV = 1 << PSC_W;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] pwm_out;
  int checks = 0, failures = 0;
  bit done = 0;

  pwm_pair6 #(.PSC_W(PSC_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  task automatic check(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic start_latency(input int ch, output int zeros);
    zeros = 0;
    while (!pwm_out[ch] && zeros < 100) begin
      zeros++;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int ch, output int hi, output int per, output int other_hi);
    int lo, g;
    hi = 0; lo = 0; other_hi = 0; g = 0;
    while (pwm_out[ch] && g < 5000) begin @(negedge clk); g++; end
    while (!pwm_out[ch] && g < 5000) begin @(negedge clk); g++; end
    while (pwm_out[ch] && g < 20000) begin
      if (pwm_out[ch^1]) other_hi++;
      hi++; @(negedge clk); g++;
    end
    while (!pwm_out[ch] && g < 20000) begin
      if (pwm_out[ch^1]) other_hi++;
      lo++; @(negedge clk); g++;
    end
    per = hi + lo;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(5'd0, d);
    check("R1 enable reset", d, 0);
    check("R1 lines after reset", pwm_out, 0);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    wr(5'd0, 8'hC0);
    rd(5'd0, d);
    check("R1 reserved bits read zero", d, 0);
    repeat (20) @(negedge clk);
    check("R1 reserved write starts nothing", pwm_out, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(5'd8, 8'd5);  wr(5'd16, 8'd2);
    wr(5'd9, 8'd3);  wr(5'd17, 8'd3);
    wr(5'd12, 8'd4); wr(5'd20, 8'd0);
    rd(5'd8, d);  check("R9 period ch0 readback", d, 5);
    rd(5'd20, d); check("R9 duty ch4 readback", d, 0);
    rd(5'd17, d); check("R9 duty ch1 readback", d, 3);
  endtask

  task automatic t_start;
    int z;
    logic [7:0] d;
    wr(5'd0, 8'h01);
    start_latency(0, z);
    check("R2 start latency ch0", z, DIV);
    rd(5'd0, d);
    check("R1 enable readback", d, 1);
  endtask

  task automatic t_wave;
    int hi, per, oh;
    measure(0, hi, per, oh);
    check("R3 high time ch0", hi, DIV * 2);
    check("R3 period ch0", per, DIV * 5);
  endtask

  task automatic t_extremes;
    int h1 = 0, h4 = 0;
    wr(5'd0, 8'h13);
    repeat (2 * DIV) @(negedge clk);
    for (int k = 0; k < 60; k++) begin
      if (pwm_out[1]) h1++;
      if (pwm_out[4]) h4++;
      @(negedge clk);
    end
    check("R8 duty>=period constantly high", h1, 60);
    check("R8 duty zero constantly low", h4, 0);
  endtask

  task automatic t_disable;
    int h = 0;
    while (!pwm_out[0]) @(negedge clk);
    wr(5'd0, 8'h12);
    check("R4 line low after clear", pwm_out[0], 0);
    for (int k = 0; k < 40; k++) begin
      if (pwm_out[0]) h++;
      @(negedge clk);
    end
    check("R4 line stays low", h, 0);
  endtask

  task automatic t_concat;
    int hi, per, oh, z, h = 0;
    wr(5'd0, 8'h00);
    wr(5'd1, 8'h02);
    wr(5'd10, 8'h01); wr(5'd11, 8'h02);
    wr(5'd18, 8'h00); wr(5'd19, 8'h81);
    wr(5'd0, 8'h04);
    for (int k = 0; k < 40; k++) begin
      if (pwm_out != 0) h++;
      @(negedge clk);
    end
    check("R6 even enable alone has no effect", h, 0);
    wr(5'd0, 8'h0C);
    measure(3, hi, per, oh);
    check("R5 16-bit high time", hi, DIV * 129);
    check("R5 16-bit period", per, DIV * 258);
    check("R6 even line low while joined", oh, 0);
    wr(5'd0, 8'h00);
    repeat (7) @(negedge clk);
    wr(5'd0, 8'h08);
    start_latency(3, z);
    check("R7 restart latency after idle", z, DIV);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_reserved();
    t_regs();
    t_start();
    t_wave();
    t_extremes();
    t_disable();
    t_concat();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule